// File: doc/BRIEF.md
# Virtual Pending Interrupt Selector with NMI Preemption

This block looks at a small array of virtual interrupt list entries and picks the one that should go to the processor next. Each entry has a two-bit state, a group bit, an eight-bit priority, an NMI flag and an interrupt ID. The scan keeps only pending entries whose group is enabled. A lower priority number wins. At equal priority an NMI entry wins, and an exact tie goes to the lowest index.

A second stage decides whether the chosen entry may preempt the current running priority. It uses the global virtual-interface enable, the virtual priority mask, the group-priority mask and the active-NMI flag. An NMI candidate is never held back by the priority mask. It may also preempt when its group priority equals the running group priority, as long as no NMI is already active. When NMI support is switched off, every NMI flag read from the list entries is forced to zero.

The scan is combinational over `NUM_LR` entries (4 to 16). The results pass through an output register when `REG_OUT` is 1, which is the default.

Top module: `virq_sel`

## Requirements
- R1: When both group enables (`grp0_en_i`, `grp1_en_i`) are low, `valid_o` and `preempt_o` are 0, whatever the list entries hold.
- R2: Only entries whose state is pending are candidates. State encoding: 2'b00 invalid, 2'b01 pending, 2'b10 active, 2'b11 pending-and-active.
- R3: Among candidates, the lowest numeric priority wins. The search starts from a best priority of all-ones, so a non-NMI entry with priority 8'hFF is never selected.
- R4: At equal priority, an NMI candidate replaces a non-NMI one, whatever their indices.
- R5: When candidates tie in both priority and NMI flag, the lowest index wins.
- R6: An entry with group bit 0 is skipped while `grp0_en_i` is low. An entry with group bit 1 is skipped while `grp1_en_i` is low.
- R7: While `vif_en_i` is low, `preempt_o` is 0.
- R8: A non-NMI winner whose priority is greater than or equal to `prio_mask_i` cannot preempt. An NMI winner ignores `prio_mask_i`.
- R9: An unmasked winner preempts when (priority AND `grp_mask_i`) is less than (`run_prio_i` AND `grp_mask_i`).
- R10: When those two group priorities are equal, the winner preempts only if it is NMI and `nmi_active_i` is low.
- R11: While `nmi_en_i` is low, every entry's NMI flag is treated as 0. This affects selection, masking, preemption and `nmi_o`.
- R12: With `REG_OUT`=1, outputs change one clock after their inputs. In reset, and whenever there is no candidate, the outputs are: `valid_o`=0, `idx_o`=0, `prio_o`=all-ones, `nmi_o`=0, `id_o`=0, `group_o`=0, `preempt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lr_state_i | input | 2*NUM_LR | Entry states, entry k at bits [2k+1:2k] |
| lr_group_i | input | NUM_LR | Entry group bits |
| lr_prio_i | input | PRIO_W*NUM_LR | Entry priorities |
| lr_nmi_i | input | NUM_LR | Entry NMI flags |
| lr_id_i | input | ID_W*NUM_LR | Entry interrupt IDs |
| grp0_en_i | input | 1 | Group 0 enable |
| grp1_en_i | input | 1 | Group 1 enable |
| vif_en_i | input | 1 | Global virtual interface enable |
| nmi_en_i | input | 1 | NMI support enable |
| prio_mask_i | input | PRIO_W | Virtual priority mask |
| grp_mask_i | input | PRIO_W | Group-priority mask |
| run_prio_i | input | PRIO_W | Current running priority |
| nmi_active_i | input | 1 | An NMI is already active |
| valid_o | output | 1 | A candidate exists |
| idx_o | output | $clog2(NUM_LR) | Winning entry index |
| prio_o | output | PRIO_W | Winning priority |
| nmi_o | output | 1 | Winner is an NMI |
| id_o | output | ID_W | Winning interrupt ID |
| group_o | output | 1 | Winning group |
| preempt_o | output | 1 | Winner may preempt |

## Verification
The assertions check on every cycle that:
- every candidate is pending and in an enabled group;
- no candidate beats the reported winner on priority, NMI flag or index;
- preemption never happens with the interface disabled or past the priority mask, except for an NMI;
- an equal-group-priority preemption always comes from an NMI with no NMI active;
- the registered outputs follow the combinational result by one clock.

Only the bench scenarios can show the expected choice for a given pattern. These include the 8'hFF boundary, a mask equal to the priority, and the effect of clearing the NMI enable on a tie. The bench also shows the one-clock latency and the exact idle values.

// File: rtl/virq_sel_pkg.sv
package virq_sel_pkg;
  typedef enum logic [1:0] {
    LR_INVALID  = 2'b00,
    LR_PENDING  = 2'b01,
    LR_ACTIVE   = 2'b10,
    LR_PEND_ACT = 2'b11
  } lr_state_e;
endpackage

// File: rtl/virq_entry_filter.sv
module virq_entry_filter
  import virq_sel_pkg::*;
#(
  parameter int NUM_LR = 8,
  parameter int PRIO_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_LR-1:0][1:0]         state_i,
  input  logic [NUM_LR-1:0]              group_i,
  input  logic [NUM_LR-1:0]              nmi_i,
  input  logic                           grp0_en_i,
  input  logic                           grp1_en_i,
  input  logic                           nmi_en_i,
  output logic [NUM_LR-1:0]              elig_o,
  output logic [NUM_LR-1:0]              nmi_o
);
  for (genvar k = 0; k < NUM_LR; k++) begin : g_ent
    logic grp_on;
    assign grp_on    = group_i[k] ? grp1_en_i : grp0_en_i;
    assign elig_o[k] = (lr_state_e'(state_i[k]) == LR_PENDING) && grp_on;
    assign nmi_o[k]  = nmi_i[k] & nmi_en_i;

    assert_pending_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_o[k] |-> (state_i[k] == 2'b01));
    assert_grp_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_o[k] |-> (group_i[k] ? grp1_en_i : grp0_en_i));
    assert_nmi_strip_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nmi_en_i |-> !nmi_o[k]);
  end
endmodule

// File: rtl/virq_pick.sv
module virq_pick #(
  parameter int NUM_LR = 8,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_LR-1:0]              elig_i,
  input  logic [NUM_LR-1:0][PRIO_W-1:0]  prio_i,
  input  logic [NUM_LR-1:0]              nmi_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [PRIO_W-1:0]              prio_o,
  output logic                           nmi_o
);
  logic              found;
  logic [IDX_W-1:0]  best_i;
  logic [PRIO_W-1:0] best_p;
  logic              best_n;

  // linear fold: strict compare keeps the earliest entry on exact ties
  always_comb begin
    found  = 1'b0;
    best_i = '0;
    best_p = '1;
    best_n = 1'b0;
    for (int k = 0; k < NUM_LR; k++) begin
      if (elig_i[k] && ((prio_i[k] < best_p) ||
                        ((prio_i[k] == best_p) && nmi_i[k] && !best_n))) begin
        found  = 1'b1;
        best_i = IDX_W'(k);
        best_p = prio_i[k];
        best_n = nmi_i[k];
      end
    end
  end

  assign valid_o = found;
  assign idx_o   = best_i;
  assign prio_o  = best_p;
  assign nmi_o   = best_n;

  assert_winner_elig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[idx_o]);

  for (genvar k = 0; k < NUM_LR; k++) begin : g_chk
    assert_none_lower_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && elig_i[k]) |-> (prio_i[k] >= prio_o));
    assert_nmi_tie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && elig_i[k] && (prio_i[k] == prio_o) && nmi_i[k]) |-> nmi_o);
    assert_low_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && elig_i[k] && (prio_i[k] == prio_o) && (nmi_i[k] == nmi_o))
        |-> (idx_o <= IDX_W'(k)));
  end
endmodule

// File: rtl/virq_preempt.sv
module virq_preempt #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              nmi_i,
  input  logic              vif_en_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  logic [PRIO_W-1:0] grp_mask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic              nmi_active_i,
  output logic              preempt_o
);
  logic [PRIO_W-1:0] cand_gp, run_gp;
  logic              masked, below, eq_nmi;

  assign cand_gp = prio_i & grp_mask_i;
  assign run_gp  = run_prio_i & grp_mask_i;
  assign masked  = !nmi_i && (prio_i >= prio_mask_i);
  assign below   = cand_gp < run_gp;
  assign eq_nmi  = (cand_gp == run_gp) && nmi_i && !nmi_active_i;

  always_comb begin
    preempt_o = 1'b0;
    if (valid_i && vif_en_i && !masked) preempt_o = below || eq_nmi;
  end

  assert_vif_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vif_en_i |-> !preempt_o);
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preempt_o && !nmi_i) |-> (prio_i < prio_mask_i));
  assert_gprio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> ((prio_i & grp_mask_i) <= (run_prio_i & grp_mask_i)));
  assert_eq_nmi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preempt_o && ((prio_i & grp_mask_i) == (run_prio_i & grp_mask_i)))
      |-> (nmi_i && !nmi_active_i));
endmodule

// File: rtl/virq_sel.sv
module virq_sel #(
  parameter int NUM_LR  = 8,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = $clog2(NUM_LR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2*NUM_LR-1:0]      lr_state_i,
  input  logic [NUM_LR-1:0]        lr_group_i,
  input  logic [PRIO_W*NUM_LR-1:0] lr_prio_i,
  input  logic [NUM_LR-1:0]        lr_nmi_i,
  input  logic [ID_W*NUM_LR-1:0]   lr_id_i,
  input  logic                     grp0_en_i,
  input  logic                     grp1_en_i,
  input  logic                     vif_en_i,
  input  logic                     nmi_en_i,
  input  logic [PRIO_W-1:0]        prio_mask_i,
  input  logic [PRIO_W-1:0]        grp_mask_i,
  input  logic [PRIO_W-1:0]        run_prio_i,
  input  logic                     nmi_active_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [PRIO_W-1:0]        prio_o,
  output logic                     nmi_o,
  output logic [ID_W-1:0]          id_o,
  output logic                     group_o,
  output logic                     preempt_o
);
  logic [NUM_LR-1:0][1:0]        state_arr;
  logic [NUM_LR-1:0][PRIO_W-1:0] prio_arr;
  logic [NUM_LR-1:0][ID_W-1:0]   id_arr;
  logic [NUM_LR-1:0]             elig, nmi_eff;

  assign state_arr = lr_state_i;
  assign prio_arr  = lr_prio_i;
  assign id_arr    = lr_id_i;

  virq_entry_filter #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_filter (
    .clk_i, .rst_ni,
    .state_i   (state_arr),
    .group_i   (lr_group_i),
    .nmi_i     (lr_nmi_i),
    .grp0_en_i, .grp1_en_i, .nmi_en_i,
    .elig_o    (elig),
    .nmi_o     (nmi_eff)
  );

  logic              c_valid, c_nmi, c_group, c_pre;
  logic [IDX_W-1:0]  c_idx;
  logic [PRIO_W-1:0] c_prio;
  logic [ID_W-1:0]   c_id;

  virq_pick #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_pick (
    .clk_i, .rst_ni,
    .elig_i  (elig),
    .prio_i  (prio_arr),
    .nmi_i   (nmi_eff),
    .valid_o (c_valid),
    .idx_o   (c_idx),
    .prio_o  (c_prio),
    .nmi_o   (c_nmi)
  );

  virq_preempt #(.PRIO_W(PRIO_W)) u_preempt (
    .clk_i, .rst_ni,
    .valid_i      (c_valid),
    .prio_i       (c_prio),
    .nmi_i        (c_nmi),
    .vif_en_i, .prio_mask_i, .grp_mask_i, .run_prio_i, .nmi_active_i,
    .preempt_o    (c_pre)
  );

  assign c_id    = c_valid ? id_arr[c_idx] : '0;
  assign c_group = c_valid & lr_group_i[c_idx];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o   <= 1'b0;
        idx_o     <= '0;
        prio_o    <= '1;
        nmi_o     <= 1'b0;
        id_o      <= '0;
        group_o   <= 1'b0;
        preempt_o <= 1'b0;
      end else begin
        valid_o   <= c_valid;
        idx_o     <= c_idx;
        prio_o    <= c_prio;
        nmi_o     <= c_nmi;
        id_o      <= c_id;
        group_o   <= c_group;
        preempt_o <= c_pre;
      end
    end

    assert_reg_lat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> ((valid_o == $past(c_valid)) && (preempt_o == $past(c_pre))));
  end else begin : g_comb
    assign valid_o   = c_valid;
    assign idx_o     = c_idx;
    assign prio_o    = c_prio;
    assign nmi_o     = c_nmi;
    assign id_o      = c_id;
    assign group_o   = c_group;
    assign preempt_o = c_pre;
  end

  assert_groups_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp0_en_i && !grp1_en_i) |-> (!c_valid && !c_pre));
  assert_idle_vals_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_valid |-> ((c_idx == '0) && (c_prio == '1) && !c_nmi && !c_pre));
endmodule

// File: tb/virq_sel_test.sv
module virq_sel_test;
  localparam int N = 8;
  localparam int P = 8;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic [1:0]   st   [N];
  logic         grp  [N];
  logic [P-1:0] pr   [N];
  logic         nm   [N];
  logic [W-1:0] idv  [N];

  logic [2*N-1:0] lr_state;
  logic [N-1:0]   lr_group, lr_nmi;
  logic [P*N-1:0] lr_prio;
  logic [W*N-1:0] lr_id;
  always_comb begin
    for (int k = 0; k < N; k++) begin
      lr_state[2*k +: 2] = st[k];
      lr_group[k]        = grp[k];
      lr_prio[P*k +: P]  = pr[k];
      lr_nmi[k]          = nm[k];
      lr_id[W*k +: W]    = idv[k];
    end
  end

  logic g0, g1, vif, nmien, nact;
  logic [P-1:0] pmask, gmask, run;
  logic valid_o, nmi_o, group_o, preempt_o;
  logic [2:0] idx_o;
  logic [P-1:0] prio_o;
  logic [W-1:0] id_o;

  virq_sel #(.NUM_LR(N), .PRIO_W(P), .ID_W(W)) uut (
    .clk_i, .rst_ni,
    .lr_state_i(lr_state), .lr_group_i(lr_group), .lr_prio_i(lr_prio),
    .lr_nmi_i(lr_nmi), .lr_id_i(lr_id),
    .grp0_en_i(g0), .grp1_en_i(g1), .vif_en_i(vif), .nmi_en_i(nmien),
    .prio_mask_i(pmask), .grp_mask_i(gmask), .run_prio_i(run),
    .nmi_active_i(nact),
    .valid_o, .idx_o, .prio_o, .nmi_o, .id_o, .group_o, .preempt_o
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    for (int k = 0; k < N; k++) begin
      st[k] = 2'b00; grp[k] = 1'b1; pr[k] = 8'h00; nm[k] = 1'b0;
      idv[k] = 16'h100 + 16'(k);
    end
    g0 = 1; g1 = 1; vif = 1; nmien = 1; nact = 0;
    pmask = 8'hFF; gmask = 8'hFF; run = 8'hFF;
  endtask

  task automatic put(input int k, input logic [1:0] s, input logic g,
                     input logic [7:0] p, input logic n);
    st[k] = s; grp[k] = g; pr[k] = p; nm[k] = n;
  endtask

  // inputs move at negedge; one register; sample at next negedge
  task automatic settle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_sel(input string req, input logic v, input int ix,
                            input logic [7:0] p, input logic n, input logic pre);
    chk(req, "valid", valid_o, v);
    if (v) begin
      chk(req, "idx", idx_o, ix);
      chk(req, "prio", prio_o, p);
      chk(req, "nmi", nmi_o, n);
      chk(req, "id", id_o, 16'h100 + 16'(ix));
    end
    chk(req, "preempt", preempt_o, pre);
  endtask

  task automatic t_reset();
    chk("R12", "rst valid", valid_o, 0);
    chk("R12", "rst idx", idx_o, 0);
    chk("R12", "rst prio", prio_o, 8'hFF);
    chk("R12", "rst nmi", nmi_o, 0);
    chk("R12", "rst id", id_o, 0);
    chk("R12", "rst group", group_o, 0);
    chk("R12", "rst preempt", preempt_o, 0);
  endtask

  task automatic t_groups();
    defaults();
    put(2, 2'b01, 1'b1, 8'h10, 1'b0);
    put(4, 2'b01, 1'b0, 8'h20, 1'b0);
    g0 = 0; g1 = 0; settle();
    expect_sel("R1", 0, 0, 0, 0, 0);
    chk("R12", "idle prio", prio_o, 8'hFF);
    chk("R12", "idle id", id_o, 0);
    g0 = 1; settle();
    expect_sel("R6", 1, 4, 8'h20, 0, 1);
    chk("R6", "group", group_o, 0);
    g0 = 0; g1 = 1; settle();
    expect_sel("R6", 1, 2, 8'h10, 0, 1);
    chk("R6", "group", group_o, 1);
  endtask

  task automatic t_pending();
    defaults();
    put(0, 2'b00, 1'b1, 8'h01, 1'b0);
    put(1, 2'b10, 1'b1, 8'h02, 1'b0);
    put(2, 2'b11, 1'b1, 8'h03, 1'b0);
    put(5, 2'b01, 1'b1, 8'h40, 1'b0);
    settle();
    expect_sel("R2", 1, 5, 8'h40, 0, 1);
  endtask

  task automatic t_prio();
    defaults();
    put(1, 2'b01, 1'b1, 8'h50, 1'b0);
    put(3, 2'b01, 1'b0, 8'h18, 1'b0);
    put(6, 2'b01, 1'b1, 8'h30, 1'b0);
    settle();
    expect_sel("R3", 1, 3, 8'h18, 0, 1);
    defaults();
    put(7, 2'b01, 1'b1, 8'hFF, 1'b0);
    settle();
    expect_sel("R3", 0, 0, 0, 0, 0);
  endtask

  task automatic t_nmi_tie();
    defaults();
    put(1, 2'b01, 1'b1, 8'h20, 1'b0);
    put(6, 2'b01, 1'b1, 8'h20, 1'b1);
    put(2, 2'b01, 1'b1, 8'h30, 1'b1);
    settle();
    expect_sel("R4", 1, 6, 8'h20, 1, 1);
    defaults();
    put(7, 2'b01, 1'b1, 8'hFF, 1'b1);
    settle();
    expect_sel("R4", 1, 7, 8'hFF, 1, 1);
  endtask

  task automatic t_tie_idx();
    defaults();
    put(7, 2'b01, 1'b1, 8'h44, 1'b0);
    put(3, 2'b01, 1'b1, 8'h44, 1'b0);
    settle();
    expect_sel("R5", 1, 3, 8'h44, 0, 1);
    put(5, 2'b01, 1'b1, 8'h44, 1'b1);
    put(6, 2'b01, 1'b1, 8'h44, 1'b1);
    settle();
    expect_sel("R5", 1, 5, 8'h44, 1, 1);
  endtask

  task automatic t_vif();
    defaults();
    put(0, 2'b01, 1'b1, 8'h10, 1'b0);
    vif = 0; settle();
    expect_sel("R7", 1, 0, 8'h10, 0, 0);
    vif = 1; settle();
    chk("R7", "preempt on", preempt_o, 1);
  endtask

  task automatic t_mask();
    defaults();
    put(0, 2'b01, 1'b1, 8'h80, 1'b0);
    pmask = 8'h80; settle();
    chk("R8", "masked eq", preempt_o, 0);
    pmask = 8'h81; settle();
    chk("R8", "unmasked", preempt_o, 1);
    pmask = 8'h80; nm[0] = 1'b1; settle();
    chk("R8", "nmi ignores mask", preempt_o, 1);
  endtask

  task automatic t_gprio();
    defaults();
    put(0, 2'b01, 1'b1, 8'h35, 1'b0);
    gmask = 8'hF0; run = 8'h48; settle();
    chk("R9", "below", preempt_o, 1);
    run = 8'h3F; settle();
    chk("R9", "equal non-nmi", preempt_o, 0);
    run = 8'h20; settle();
    chk("R9", "above", preempt_o, 0);
  endtask

  task automatic t_eq_nmi();
    defaults();
    put(0, 2'b01, 1'b1, 8'h35, 1'b1);
    gmask = 8'hF0; run = 8'h3F; settle();
    chk("R10", "eq nmi free", preempt_o, 1);
    nact = 1; settle();
    chk("R10", "eq nmi active", preempt_o, 0);
    run = 8'h48; settle();
    chk("R10", "below with active", preempt_o, 1);
  endtask

  task automatic t_nmi_off();
    defaults();
    nmien = 0;
    put(1, 2'b01, 1'b1, 8'h20, 1'b0);
    put(6, 2'b01, 1'b1, 8'h20, 1'b1);
    settle();
    expect_sel("R11", 1, 1, 8'h20, 0, 1);
    defaults();
    nmien = 0;
    put(0, 2'b01, 1'b1, 8'h80, 1'b1);
    pmask = 8'h80; settle();
    expect_sel("R11", 1, 0, 8'h80, 0, 0);
    defaults();
    nmien = 0;
    put(7, 2'b01, 1'b1, 8'hFF, 1'b1);
    settle();
    expect_sel("R11", 0, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    defaults();
    put(4, 2'b01, 1'b1, 8'h12, 1'b0);
    settle();
    chk("R12", "before", idx_o, 4);
    put(2, 2'b01, 1'b1, 8'h11, 1'b0);
    #1;
    chk("R12", "held until edge", idx_o, 4);
    @(posedge clk_i); #1;
    chk("R12", "after edge", idx_o, 2);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_groups();
    t_pending();
    t_prio();
    t_nmi_tie();
    t_tie_idx();
    t_vif();
    t_mask();
    t_gprio();
    t_eq_nmi();
    t_nmi_off();
    t_latency();
    finish_run();
  end
endmodule